// File: doc/BRIEF.md
# In-Order Load Return Unit

This block sits between the load/store issue stage and the register write stage of a processor core. It accepts load and store issues carrying a tag, an access size, a signedness flag and the low address bits. It traps accesses whose address is not aligned to their size. For every aligned load it keeps an entry until the data cache has answered, and then hands the result to the write stage. Results come back strictly in issue order, never more than one per cycle.

The cache answers each accepted load in the cycle after issue, with either a hit and its data or a miss. Fill data for misses arrives later, one fill per miss, in the order the misses were reported. A hit normally returns two cycles after issue. A signed load narrower than 64 bits takes one extra cycle. It also switches on a delayed mode that gives the same extra cycle to every load issued in the cycles directly after it. The mode lasts until a cycle passes with no load issued. A pending miss holds back every younger load, including ones that hit.

Top module: `ldret_unit`

## Requirements
- R1: A hit load that is not a signed narrow load, issued while delayed mode is off, asserts ret_valid_o exactly 2 cycles after its issue cycle.
- R2: A signed load of size code 0, 1 or 2 (8, 16 or 32 bits) that hits asserts ret_valid_o exactly 3 cycles after its issue cycle.
- R3: Results return in issue order; a younger hit behind an unfilled miss returns only after the miss has returned.
- R4: Any load issued in a cycle that directly follows a load issued while the mode was on, or a signed narrow load, gets the 3-cycle hit latency; the first cycle with no load issued turns the mode off.
- R5: A load or store whose low address bits are not a multiple of its access size (2 to the power of the size code bytes) raises trap_o in the cycle after issue and creates no return; an aligned store creates neither a trap nor a return.
- R6: A miss returns in the cycle after its fill arrives, but never earlier than its hit latency; ret_valid_o carries at most one result per cycle.
- R7: With DEPTH loads outstanding, ld_ready_o is low, and an issue attempted while it is low is ignored.
- R8: Size codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits taken from the low end of the cache data; narrower results are sign-extended when ld_signed_i was set and zero-extended otherwise.
- R9: Reset discards all outstanding loads and turns delayed mode off.
- R10: A fill is applied to the oldest load whose lookup reported a miss and that has not been filled yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Issue request valid |
| ld_ready_o | output | 1 | Issue accepted when high |
| ld_store_i | input | 1 | Access is a store (alignment check only) |
| ld_tag_i | input | TAG_W | Destination tag of the load |
| ld_size_i | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| ld_signed_i | input | 1 | Sign-extend the result |
| ld_addr_lo_i | input | OFFS_W | Low address bits inside one data word |
| lkp_hit_i | input | 1 | Cache lookup hit, valid in the cycle after an accepted aligned load |
| lkp_data_i | input | DATA_W | Hit data, right aligned |
| fill_valid_i | input | 1 | Fill data for the oldest unfilled miss |
| fill_data_i | input | DATA_W | Fill data, right aligned |
| ret_valid_o | output | 1 | Result valid this cycle |
| ret_tag_o | output | TAG_W | Tag of the returned load |
| ret_data_o | output | DATA_W | Extended result |
| trap_o | output | 1 | Misaligned access trap, one cycle |

## Verification
The assertions assume an orderly cache. Fills come only while some looked-up miss is still unfilled. Lookup results appear exactly in the cycle after an accepted aligned load. The bench models the cache under these rules. It keeps the lookup answer for each accepted load in a slot indexed by issue cycle and drives it one cycle later. It queues the fills in miss order, spacing them at least one cycle apart and never before the cycle after the lookup. A load refused while ld_ready_o is low is never given to this model.

// File: rtl/ldret_pkg.sv
package ldret_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;

  localparam logic [1:0] LAT_FAST = 2'd1; // countdown seeds: ready 2 cycles after issue
  localparam logic [1:0] LAT_SLOW = 2'd2; // ready 3 cycles after issue
endpackage

// File: rtl/ldret_align.sv
module ldret_align
  import ldret_pkg::*;
#(
  parameter int OFFS_W = 3
) (
  input  size_e             size_i,
  input  logic [OFFS_W-1:0] addr_lo_i,
  output logic              misaligned_o
);
  logic [OFFS_W-1:0] mask;

  always_comb begin
    mask         = OFFS_W'((1 << size_i) - 1);
    misaligned_o = |(addr_lo_i & mask);
  end
endmodule

// File: rtl/ldret_extend.sv
module ldret_extend
  import ldret_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] raw_i,
  input  size_e             size_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] msb_idx;
  logic             fill_bit;

  always_comb begin
    msb_idx  = IDX_W'((8 << size_i) - 1);
    fill_bit = sgn_i & raw_i[msb_idx];
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_o[b] = (IDX_W'(b) <= msb_idx) ? raw_i[b] : fill_bit;
  end
endmodule

// File: rtl/ldret_queue.sv
module ldret_queue
  import ldret_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  size_e             wr_size_i,
  input  logic              wr_sgn_i,
  input  logic              wr_slow_i,
  input  logic              lkp_hit_i,
  input  logic [DATA_W-1:0] lkp_data_i,
  input  logic              fill_en_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              full_o,
  output logic              head_vld_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output size_e             head_size_o,
  output logic              head_sgn_o,
  output logic [DATA_W-1:0] head_data_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic              e_vld  [DEPTH];
  logic              e_have [DEPTH];
  logic              e_miss [DEPTH];
  logic [1:0]        e_dly  [DEPTH];
  logic [TAG_W-1:0]  e_tag  [DEPTH];
  size_e             e_size [DEPTH];
  logic              e_sgn  [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, lk_ptr_q;
  logic             lk_pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;
  logic             fill_found;
  logic [PTR_W-1:0] fill_idx, scan_idx;

  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign pop         = e_vld[rd_ptr_q] & e_have[rd_ptr_q] & (e_dly[rd_ptr_q] == 2'd0);
  assign head_vld_o  = pop;
  assign head_tag_o  = e_tag[rd_ptr_q];
  assign head_size_o = e_size[rd_ptr_q];
  assign head_sgn_o  = e_sgn[rd_ptr_q];
  assign head_data_o = e_data[rd_ptr_q];

  // oldest looked-up miss still waiting for its fill
  always_comb begin
    fill_found = 1'b0;
    fill_idx   = rd_ptr_q;
    scan_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      scan_idx = rd_ptr_q + PTR_W'(i);
      if (e_vld[scan_idx] && e_miss[scan_idx] && !e_have[scan_idx]) begin
        fill_found = 1'b1;
        fill_idx   = scan_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      lk_ptr_q  <= '0;
      lk_pend_q <= 1'b0;
      cnt_q     <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_vld[i]  <= 1'b0;
        e_have[i] <= 1'b0;
        e_miss[i] <= 1'b0;
        e_dly[i]  <= 2'd0;
        e_tag[i]  <= '0;
        e_size[i] <= SZ_B;
        e_sgn[i]  <= 1'b0;
        e_data[i] <= '0;
      end
    end else begin
      lk_pend_q <= wr_en_i;
      if (wr_en_i) begin
        lk_ptr_q <= wr_ptr_q;
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
      if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(wr_en_i) - CNT_W'(pop);

      for (int i = 0; i < DEPTH; i++) begin
        if (e_dly[i] != 2'd0) e_dly[i] <= e_dly[i] - 2'd1;
        if (wr_en_i && wr_ptr_q == PTR_W'(i)) begin
          e_vld[i]  <= 1'b1;
          e_have[i] <= 1'b0;
          e_miss[i] <= 1'b0;
          e_dly[i]  <= wr_slow_i ? LAT_SLOW : LAT_FAST;
          e_tag[i]  <= wr_tag_i;
          e_size[i] <= wr_size_i;
          e_sgn[i]  <= wr_sgn_i;
        end else begin
          if (pop && rd_ptr_q == PTR_W'(i)) e_vld[i] <= 1'b0;
          if (lk_pend_q && lk_ptr_q == PTR_W'(i)) begin
            if (lkp_hit_i) begin
              e_have[i] <= 1'b1;
              e_data[i] <= lkp_data_i;
            end else begin
              e_miss[i] <= 1'b1;
            end
          end
          if (fill_en_i && fill_found && fill_idx == PTR_W'(i)) begin
            e_have[i] <= 1'b1;
            e_data[i] <= fill_data_i;
          end
        end
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o);

  // R10
  fill_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> fill_found);

  // R1
  early_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> !(lk_pend_q && lk_ptr_q == rd_ptr_q));

  // R6
  single_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (cnt_q == $past(cnt_q) - CNT_W'(1) + CNT_W'($past(wr_en_i))));
endmodule

// File: rtl/ldret_unit.sv
module ldret_unit
  import ldret_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64,
  localparam int OFFS_W = $clog2(DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic              ld_store_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [1:0]        ld_size_i,
  input  logic              ld_signed_i,
  input  logic [OFFS_W-1:0] ld_addr_lo_i,
  input  logic              lkp_hit_i,
  input  logic [DATA_W-1:0] lkp_data_i,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              ret_valid_o,
  output logic [TAG_W-1:0]  ret_tag_o,
  output logic [DATA_W-1:0] ret_data_o,
  output logic              trap_o
);
  size_e             size;
  logic              misaligned, full, fire, ld_fire, mis_fire;
  logic              narrow_sgn, slow, slow_q, trap_q;
  size_e             head_size;
  logic              head_sgn;
  logic [DATA_W-1:0] head_data;

  assign size       = size_e'(ld_size_i);
  assign ld_ready_o = !full;
  assign fire       = ld_valid_i & !full;
  assign ld_fire    = fire & !ld_store_i & !misaligned;
  assign mis_fire   = fire & misaligned;
  assign narrow_sgn = ld_signed_i & (size != SZ_D);
  assign slow       = narrow_sgn | slow_q;
  assign trap_o     = trap_q;

  ldret_align #(.OFFS_W(OFFS_W)) u_align (
    .size_i      (size),
    .addr_lo_i   (ld_addr_lo_i),
    .misaligned_o(misaligned)
  );

  // delayed mode survives only back-to-back load issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      slow_q <= ld_fire & slow;
      trap_q <= mis_fire;
    end
  end

  ldret_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ld_fire),
    .wr_tag_i   (ld_tag_i),
    .wr_size_i  (size),
    .wr_sgn_i   (ld_signed_i),
    .wr_slow_i  (slow),
    .lkp_hit_i  (lkp_hit_i),
    .lkp_data_i (lkp_data_i),
    .fill_en_i  (fill_valid_i),
    .fill_data_i(fill_data_i),
    .full_o     (full),
    .head_vld_o (ret_valid_o),
    .head_tag_o (ret_tag_o),
    .head_size_o(head_size),
    .head_sgn_o (head_sgn),
    .head_data_o(head_data)
  );

  ldret_extend #(.DATA_W(DATA_W)) u_ext (
    .raw_i (head_data),
    .size_i(head_size),
    .sgn_i (head_sgn),
    .data_o(ret_data_o)
  );

  // R4
  delay_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ld_fire) |-> !slow_q);

  // R5
  trap_no_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !$past(ld_fire));
endmodule

// File: tb/ldret_unit_tb.sv
module ldret_unit_tb;
  localparam int NV = 10;
  localparam logic [63:0] RA = 64'h1234_5678_9ABC_DEF5;
  localparam logic [63:0] RB = 64'h1234_5678_9ABC_7EF5;
  // {size[2], signed, hit, fill_delay[4], raw[64], latency[8], expected[64]}
  localparam logic [143:0] TBL [NV] = '{
    {2'd0, 1'b0, 1'b1, 4'd0, RA, 8'd2, 64'h0000_0000_0000_00F5},
    {2'd0, 1'b1, 1'b1, 4'd0, RA, 8'd3, 64'hFFFF_FFFF_FFFF_FFF5},
    {2'd1, 1'b1, 1'b1, 4'd0, RB, 8'd3, 64'h0000_0000_0000_7EF5},
    {2'd1, 1'b0, 1'b1, 4'd0, RA, 8'd2, 64'h0000_0000_0000_DEF5},
    {2'd2, 1'b1, 1'b1, 4'd0, RA, 8'd3, 64'hFFFF_FFFF_9ABC_DEF5},
    {2'd2, 1'b0, 1'b1, 4'd0, RA, 8'd2, 64'h0000_0000_9ABC_DEF5},
    {2'd3, 1'b1, 1'b1, 4'd0, RA, 8'd2, RA},
    {2'd0, 1'b0, 1'b0, 4'd3, RA, 8'd6, 64'h0000_0000_0000_00F5},
    {2'd2, 1'b1, 1'b0, 4'd0, RA, 8'd3, 64'hFFFF_FFFF_9ABC_DEF5},
    {2'd3, 1'b0, 1'b0, 4'd5, RA, 8'd8, RA}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ld_valid = 1'b0, ld_store = 1'b0, ld_signed = 1'b0;
  logic [3:0] ld_tag = '0;
  logic [1:0] ld_size = '0;
  logic [2:0] ld_addr = '0;
  logic lkp_hit = 1'b0, fill_valid = 1'b0;
  logic [63:0] lkp_data = '0, fill_data = '0;
  logic ld_ready, ret_valid, trap;
  logic [3:0] ret_tag;
  logic [63:0] ret_data;

  int cyc = 0, checks = 0, errs = 0;
  int iss_cyc [16];
  bit lk_v [4];
  logic lk_h [4];
  logic [63:0] lk_d [4];
  int fq_at [64];
  logic [63:0] fq_dat [64];
  int fq_wr = 0, fq_rd = 0, last_at = 0;
  int rv_n = 0, tr_n = 0, tr_cyc = 0;
  logic [3:0] rv_tag [64];
  logic [63:0] rv_dat [64];
  int rv_cyc [64];

  ldret_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_valid_i(ld_valid), .ld_ready_o(ld_ready),
    .ld_store_i(ld_store), .ld_tag_i(ld_tag), .ld_size_i(ld_size),
    .ld_signed_i(ld_signed), .ld_addr_lo_i(ld_addr), .lkp_hit_i(lkp_hit),
    .lkp_data_i(lkp_data), .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .ret_valid_o(ret_valid), .ret_tag_o(ret_tag), .ret_data_o(ret_data),
    .trap_o(trap)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // cache model: lookup one cycle after issue, fills in miss order
  always @(negedge clk) begin
    int s;
    s = (cyc + 3) % 4;
    if (lk_v[s]) begin
      lkp_hit = lk_h[s]; lkp_data = lk_d[s]; lk_v[s] = 1'b0;
    end else begin
      lkp_hit = 1'b0; lkp_data = '0;
    end
    if (fq_rd < fq_wr && fq_at[fq_rd] == cyc) begin
      fill_valid = 1'b1; fill_data = fq_dat[fq_rd]; fq_rd++;
    end else begin
      fill_valid = 1'b0; fill_data = '0;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && ret_valid) begin
      rv_tag[rv_n] = ret_tag; rv_dat[rv_n] = ret_data; rv_cyc[rv_n] = cyc; rv_n++;
    end
    if (rst_ni && trap) begin
      tr_n++; tr_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic issue_ld(input logic [3:0] tag, input logic [1:0] sz, input logic sg,
                          input logic [2:0] addr, input logic st, input logic hit,
                          input logic [63:0] raw, input int fd, output bit acc);
    int at;
    acc = ld_ready;
    ld_valid = 1'b1; ld_tag = tag; ld_size = sz; ld_signed = sg; ld_addr = addr; ld_store = st;
    if (acc) begin
      iss_cyc[tag] = cyc;
      if (!st && ((int'(addr) & ((1 << sz) - 1)) == 0)) begin
        lk_v[cyc % 4] = 1'b1; lk_h[cyc % 4] = hit; lk_d[cyc % 4] = raw;
        if (!hit) begin
          at = cyc + 2 + fd;
          if (fq_wr > fq_rd && at <= last_at) at = last_at + 1;
          fq_at[fq_wr] = at; fq_dat[fq_wr] = raw; fq_wr++; last_at = at;
        end
      end
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit acc;
    string rq;
    for (int i = 0; i < 4; i++) lk_v[i] = 1'b0;
    idle(3);
    // R9 reset state
    chk(ret_valid == 1'b0, "R9 ret_valid in reset", 64'(ret_valid), 64'h0);
    chk(trap == 1'b0, "R9 trap in reset", 64'(trap), 64'h0);
    rst_ni = 1'b1;
    idle(2);
    chk(ld_ready == 1'b1, "R9 ready after reset", 64'(ld_ready), 64'h1);

    // table walk: single loads on an idle unit (R1 R2 R6 R8)
    for (int i = 0; i < NV; i++) begin
      logic [143:0] v;
      v = TBL[i];
      rv_n = 0;
      rq = !v[140] ? "R6 miss latency" : ((v[141] && v[143:142] != 2'd3) ? "R2 latency" : "R1 latency");
      issue_ld(4'(i), v[143:142], v[141], 3'd0, 1'b0, v[140], v[135:72], int'(v[139:136]), acc);
      idle(14);
      chk(rv_n == 1, "R6 one return per load", 64'(rv_n), 64'h1);
      chk(rv_cyc[0] - iss_cyc[i] == int'(v[71:64]), rq, 64'(rv_cyc[0] - iss_cyc[i]), 64'(v[71:64]));
      chk(rv_dat[0] == v[63:0], "R8 extended data", rv_dat[0], v[63:0]);
      chk(rv_tag[0] == 4'(i), "R3 tag", 64'(rv_tag[0]), 64'(i));
    end

    // R4 delayed mode chain, ended by an idle cycle
    rv_n = 0;
    issue_ld(4'd1, 2'd0, 1'b1, 3'd0, 1'b0, 1'b1, RA, 0, acc);
    issue_ld(4'd2, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1, RA, 0, acc);
    issue_ld(4'd3, 2'd2, 1'b0, 3'd4, 1'b0, 1'b1, RA, 0, acc);
    idle(1);
    issue_ld(4'd4, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, RA, 0, acc);
    idle(10);
    chk(rv_n == 4, "R4 return count", 64'(rv_n), 64'h4);
    chk(rv_cyc[1] - iss_cyc[2] == 3, "R4 follower latency", 64'(rv_cyc[1] - iss_cyc[2]), 64'h3);
    chk(rv_cyc[2] - iss_cyc[3] == 3, "R4 second follower latency", 64'(rv_cyc[2] - iss_cyc[3]), 64'h3);
    chk(rv_cyc[3] - iss_cyc[4] == 2, "R4 mode off after idle", 64'(rv_cyc[3] - iss_cyc[4]), 64'h2);

    // R3 miss holds back younger hits
    rv_n = 0;
    issue_ld(4'd5, 2'd3, 1'b0, 3'd0, 1'b0, 1'b0, RA, 4, acc);
    issue_ld(4'd6, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1, RB, 0, acc);
    issue_ld(4'd7, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, RB, 0, acc);
    idle(14);
    chk(rv_n == 3, "R3 return count", 64'(rv_n), 64'h3);
    chk(rv_tag[0] == 4'd5 && rv_tag[1] == 4'd6 && rv_tag[2] == 4'd7, "R3 order",
        {52'h0, rv_tag[0], rv_tag[1], rv_tag[2]}, 64'h567);
    chk(rv_cyc[0] - iss_cyc[5] == 7, "R6 miss after fill", 64'(rv_cyc[0] - iss_cyc[5]), 64'h7);
    chk(rv_cyc[1] == rv_cyc[0] + 1 && rv_cyc[2] == rv_cyc[0] + 2, "R3 blocked hits drain",
        64'(rv_cyc[2] - rv_cyc[0]), 64'h2);

    // R5 misalignment traps
    rv_n = 0; tr_n = 0;
    issue_ld(4'd8, 2'd1, 1'b0, 3'd1, 1'b0, 1'b1, RA, 0, acc);
    idle(4);
    chk(tr_n == 1 && tr_cyc - iss_cyc[8] == 1, "R5 half trap timing", 64'(tr_cyc - iss_cyc[8]), 64'h1);
    issue_ld(4'd9, 2'd2, 1'b1, 3'd2, 1'b0, 1'b1, RA, 0, acc);
    issue_ld(4'd10, 2'd3, 1'b0, 3'd4, 1'b0, 1'b1, RA, 0, acc);
    issue_ld(4'd11, 2'd2, 1'b0, 3'd6, 1'b1, 1'b1, RA, 0, acc);
    issue_ld(4'd12, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, RA, 0, acc);
    idle(6);
    chk(tr_n == 4, "R5 trap count", 64'(tr_n), 64'h4);
    chk(rv_n == 0, "R5 no return for trap or store", 64'(rv_n), 64'h0);
    issue_ld(4'd13, 2'd0, 1'b0, 3'd3, 1'b0, 1'b1, RA, 0, acc);
    idle(6);
    chk(rv_n == 1 && tr_n == 4, "R5 byte at odd address", 64'(rv_n), 64'h1);

    // R7 full queue
    rv_n = 0;
    for (int i = 0; i < 8; i++) issue_ld(4'(i), 2'd3, 1'b0, 3'd0, 1'b0, 1'b0, RA + 64'(i), 20, acc);
    chk(ld_ready == 1'b0, "R7 ready low when full", 64'(ld_ready), 64'h0);
    issue_ld(4'd9, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1, RA, 0, acc);
    chk(acc == 1'b0, "R7 issue refused", 64'(acc), 64'h0);
    idle(40);
    chk(rv_n == 8, "R7 refused load absent", 64'(rv_n), 64'h8);
    for (int i = 0; i < 8; i++)
      chk(rv_tag[i] == 4'(i) && rv_dat[i] == RA + 64'(i), "R10 fill order", rv_dat[i], RA + 64'(i));
    chk(ld_ready == 1'b1, "R7 ready after drain", 64'(ld_ready), 64'h1);

    // R9 reset discards loads and delayed mode
    rv_n = 0;
    issue_ld(4'd3, 2'd3, 1'b0, 3'd0, 1'b0, 1'b0, RA, 10, acc);
    issue_ld(4'd2, 2'd0, 1'b1, 3'd0, 1'b0, 1'b1, RA, 0, acc);
    rst_ni = 1'b0;
    for (int i = 0; i < 4; i++) lk_v[i] = 1'b0;
    fq_rd = fq_wr;
    idle(2);
    for (int i = 0; i < 4; i++) lk_v[i] = 1'b0;
    rst_ni = 1'b1;
    issue_ld(4'd4, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1, RA, 0, acc);
    idle(20);
    chk(rv_n == 1 && rv_tag[0] == 4'd4, "R9 outstanding loads dropped", 64'(rv_n), 64'h1);
    chk(rv_cyc[0] - iss_cyc[4] == 2, "R9 delayed mode cleared", 64'(rv_cyc[0] - iss_cyc[4]), 64'h2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule